// File: doc/BRIEF.md
# Memory Type Range Resolver

This block maps a physical address to the cache memory type that governs it. It keeps a bank of range registers: an 88-entry fixed-range table for the lowest megabyte, a set of variable base/mask range pairs, a default-type register carrying the enables, and a top-of-memory-2 register. Software fills these registers through a one-cycle write port that carries a register index and 64 bits of data.

A lookup port takes an address together with a valid strobe. The resolved type is registered and appears on the next clock edge with its own valid flag. When both apply, fixed ranges take priority over the top-of-memory-2 window. That window takes priority over variable ranges. Variable ranges take priority over the default type. When several variable ranges cover the same address, their types are combined by precedence rules.

Top module: `mtr_resolver`

## Requirements
- R1: Type codes are uncacheable = 0, write-combining = 1, write-through = 4, write-protect = 5, write-back = 6. Any other stored code is stored unchanged but resolves as uncacheable, and every valid result is one of these five codes.
- R2: Register indices on the write port are: 0..10 for the fixed table (each register holds eight 8-bit types, lowest address in bits 7:0); 16+2k for the base of variable range k (address bits 39:12, type in bits 7:0); 17+2k for its mask (mask bits 39:12, active flag in bit 11); 32 for the default register (type in bits 7:0, fixed enable in bit 10, global enable in bit 11); 33 for top-of-memory-2 (bits 47:23 kept, the rest read as zero).
- R3: res_valid is high exactly one clock after a cycle with lk_valid high and is low otherwise. res_type then holds the result for that address.
- R4: Reset clears every register. While the global enable is clear, every lookup returns uncacheable.
- R5: With both enables set, an address below 0x100000 takes its type from the fixed table and ignores all other ranges. 0x00000-0x7FFFF maps to entries 0-7 in 64 KB steps. 0x80000-0xBFFFF maps to entries 8-23 in 16 KB steps. 0xC0000-0xFFFFF maps to entries 24-87 in 4 KB steps.
- R6: With the fixed enable clear, addresses below 0x100000 resolve through the variable ranges and the default type.
- R7: A variable range takes part only when its active flag is set. It covers an address when the address ANDed with the mask equals the base ANDed with the mask, on page-aligned values.
- R8: Covering variable ranges combine pairwise: uncacheable with anything gives uncacheable; write-back with write-through gives write-through; other unequal pairs give uncacheable; equal types stay unchanged.
- R9: An address covered by no variable range resolves to the default type.
- R10: When top-of-memory-2 is nonzero, addresses at or above 4 GiB and below its 8 MiB-aligned value resolve to write-back, overriding the variable ranges. A zero value disables the window.
- R11: A register write in the same cycle as a lookup affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index |
| wr_data | input | 64 | Register write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 40 | Physical address to resolve |
| res_valid | output | 1 | Result valid, one clock after lk_valid |
| res_type | output | 8 | Resolved memory type |

## Verification
The checker assumes that the default register is written only through index 32, so it can track the global enable from the write port alone. It also assumes that lookups and writes are plain single-cycle strobes with no other side channel. The bench drives every write and lookup on the falling edge as one-cycle pulses. It only writes to the documented indices, and it writes the default register whenever it changes an enable. This keeps the checker's view of the enable equal to the design's own.

// File: rtl/mtr_pkg.sv
`timescale 1ns/1ps
package mtr_pkg;
  localparam int TYPE_W     = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int FIX_REGS   = 11;
  localparam int FIX_TOP    = 20;
  localparam int TOM2_W     = 48;
  localparam int TOM2_LSB   = 23;

  localparam logic [TYPE_W-1:0] MT_UC = 8'd0;
  localparam logic [TYPE_W-1:0] MT_WC = 8'd1;
  localparam logic [TYPE_W-1:0] MT_WT = 8'd4;
  localparam logic [TYPE_W-1:0] MT_WP = 8'd5;
  localparam logic [TYPE_W-1:0] MT_WB = 8'd6;

  function automatic logic [TYPE_W-1:0] mt_clean(input logic [TYPE_W-1:0] t);
    case (t)
      MT_UC, MT_WC, MT_WT, MT_WP, MT_WB: mt_clean = t;
      default:                           mt_clean = MT_UC;
    endcase
  endfunction

  function automatic logic [TYPE_W-1:0] mt_merge(input logic [TYPE_W-1:0] a_in,
                                                 input logic [TYPE_W-1:0] b_in);
    logic [TYPE_W-1:0] a, b;
    a = mt_clean(a_in);
    b = mt_clean(b_in);
    if (a == MT_UC || b == MT_UC)
      mt_merge = MT_UC;
    else if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB))
      mt_merge = MT_WT;
    else if (a != b)
      mt_merge = MT_UC;
    else
      mt_merge = a;
  endfunction
endpackage

// File: rtl/mtr_cfg_regs.sv
`timescale 1ns/1ps
module mtr_cfg_regs
  import mtr_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int NUM_VAR = 8,
  parameter int IDX_W   = 6,
  parameter int VAR_IDX = 16,
  parameter int DEF_IDX = 32,
  parameter int TM2_IDX = 33
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [63:0]                       wr_data,
  output logic [FIX_REGS-1:0][63:0]         fix_q,
  output logic [NUM_VAR-1:0][ADDR_W-1:0]    vbase_q,
  output logic [NUM_VAR-1:0][ADDR_W-1:0]    vmask_q,
  output logic [NUM_VAR-1:0][TYPE_W-1:0]    vtype_q,
  output logic [NUM_VAR-1:0]                vact_q,
  output logic [TYPE_W-1:0]                 def_type_q,
  output logic                              glob_en_q,
  output logic                              fix_en_q,
  output logic [TOM2_W-1:0]                 tom2_q
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  for (genvar r = 0; r < FIX_REGS; r++) begin : g_fix
    always_ff @(posedge clk) begin
      if (rst)
        fix_q[r] <= '0;
      else if (wr_en && wr_idx == IDX_W'(r))
        fix_q[r] <= wr_data;
    end
  end

  for (genvar k = 0; k < NUM_VAR; k++) begin : g_var
    always_ff @(posedge clk) begin
      if (rst) begin
        vbase_q[k] <= '0;
        vtype_q[k] <= MT_UC;
        vmask_q[k] <= '0;
        vact_q[k]  <= 1'b0;
      end else if (wr_en) begin
        if (wr_idx == IDX_W'(VAR_IDX + 2*k)) begin
          vbase_q[k] <= {wr_data[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
          vtype_q[k] <= wr_data[TYPE_W-1:0];
        end
        if (wr_idx == IDX_W'(VAR_IDX + 2*k + 1)) begin
          vmask_q[k] <= {wr_data[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
          vact_q[k]  <= wr_data[11];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      def_type_q <= MT_UC;
      glob_en_q  <= 1'b0;
      fix_en_q   <= 1'b0;
      tom2_q     <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(DEF_IDX)) begin
        def_type_q <= wr_data[TYPE_W-1:0];
        fix_en_q   <= wr_data[10];
        glob_en_q  <= wr_data[11];
      end
      if (wr_idx == IDX_W'(TM2_IDX))
        tom2_q <= {wr_data[TOM2_W-1:TOM2_LSB], {TOM2_LSB{1'b0}}};
    end
  end

  logic [PG_W-1:0] unused_pg;
  assign unused_pg = '0;
endmodule

// File: rtl/mtr_fixed_lookup.sv
`timescale 1ns/1ps
module mtr_fixed_lookup
  import mtr_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:PAGE_SHIFT]  pg_addr,
  input  logic [FIX_REGS-1:0][63:0]   fix_q,
  output logic                        in_low,
  output logic [TYPE_W-1:0]           fix_type
);
  logic [6:0]  ent;
  logic [63:0] word;

  assign in_low = (pg_addr[ADDR_W-1:FIX_TOP] == '0);

  always_comb begin
    if (!pg_addr[19])
      ent = {4'd0, pg_addr[18:16]};
    else if (!pg_addr[18])
      ent = 7'd8 + {3'd0, pg_addr[17:14]};
    else
      ent = 7'd24 + {1'b0, pg_addr[17:12]};
  end

  always_comb begin
    word = '0;
    for (int r = 0; r < FIX_REGS; r++)
      if (ent[6:3] == 4'(r)) word = fix_q[r];
  end

  assign fix_type = word[ent[2:0]*8 +: 8];
endmodule

// File: rtl/mtr_var_lookup.sv
`timescale 1ns/1ps
module mtr_var_lookup
  import mtr_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int NUM_VAR = 8
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_VAR-1:0][ADDR_W-1:0]   vbase_q,
  input  logic [NUM_VAR-1:0][ADDR_W-1:0]   vmask_q,
  input  logic [NUM_VAR-1:0][TYPE_W-1:0]   vtype_q,
  input  logic [NUM_VAR-1:0]               vact_q,
  output logic                             var_any,
  output logic [TYPE_W-1:0]                var_type
);
  logic [NUM_VAR-1:0] hit;

  for (genvar k = 0; k < NUM_VAR; k++) begin : g_hit
    assign hit[k] = vact_q[k] && (((addr ^ vbase_q[k]) & vmask_q[k]) == '0);
  end

  always_comb begin
    var_any  = 1'b0;
    var_type = MT_UC;
    for (int k = 0; k < NUM_VAR; k++) begin
      if (hit[k]) begin
        var_type = var_any ? mt_merge(var_type, vtype_q[k]) : mt_clean(vtype_q[k]);
        var_any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtr_resolver.sv
`timescale 1ns/1ps
module mtr_resolver
  import mtr_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_VAR   = 8,
  parameter bit HAS_FIXED = 1'b1,
  parameter int VAR_IDX   = 16,
  parameter int DEF_IDX   = VAR_IDX + 2*NUM_VAR,
  parameter int TM2_IDX   = DEF_IDX + 1,
  parameter int IDX_W     = $clog2(TM2_IDX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [63:0]       wr_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic [7:0]        res_type
);
  localparam int HI_LSB = 32;

  logic [FIX_REGS-1:0][63:0]       fix_q;
  logic [NUM_VAR-1:0][ADDR_W-1:0]  vbase_q, vmask_q;
  logic [NUM_VAR-1:0][TYPE_W-1:0]  vtype_q;
  logic [NUM_VAR-1:0]              vact_q;
  logic [TYPE_W-1:0]               def_type_q;
  logic                            glob_en_q, fix_en_q;
  logic [TOM2_W-1:0]               tom2_q;

  mtr_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .IDX_W(IDX_W),
    .VAR_IDX(VAR_IDX), .DEF_IDX(DEF_IDX), .TM2_IDX(TM2_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fix_q(fix_q), .vbase_q(vbase_q), .vmask_q(vmask_q), .vtype_q(vtype_q),
    .vact_q(vact_q), .def_type_q(def_type_q), .glob_en_q(glob_en_q),
    .fix_en_q(fix_en_q), .tom2_q(tom2_q)
  );

  logic              in_low;
  logic [TYPE_W-1:0] fix_type;
  logic              fix_take;

  if (HAS_FIXED) begin : g_fixed
    mtr_fixed_lookup #(.ADDR_W(ADDR_W)) u_fix (
      .pg_addr(lk_addr[ADDR_W-1:PAGE_SHIFT]), .fix_q(fix_q),
      .in_low(in_low), .fix_type(fix_type)
    );
    assign fix_take = fix_en_q && in_low;
  end else begin : g_nofixed
    assign in_low   = 1'b0;
    assign fix_type = MT_UC;
    assign fix_take = 1'b0;
  end

  logic              var_any;
  logic [TYPE_W-1:0] var_type;

  mtr_var_lookup #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
    .addr(lk_addr), .vbase_q(vbase_q), .vmask_q(vmask_q), .vtype_q(vtype_q),
    .vact_q(vact_q), .var_any(var_any), .var_type(var_type)
  );

  logic [TOM2_W-1:0] addr_x;
  logic              tom2_hit;
  assign addr_x   = TOM2_W'(lk_addr);
  assign tom2_hit = (tom2_q != '0) && (lk_addr[ADDR_W-1:HI_LSB] != '0) && (addr_x < tom2_q);

  logic [TYPE_W-1:0] resolved;
  always_comb begin
    if (!glob_en_q)
      resolved = MT_UC;
    else if (fix_take)
      resolved = mt_clean(fix_type);
    else if (tom2_hit)
      resolved = MT_WB;
    else if (var_any)
      resolved = var_type;
    else
      resolved = mt_clean(def_type_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_type  <= MT_UC;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid)
        res_type <= resolved;
    end
  end
endmodule

// File: rtl/mtr_resolver_chk.sv
`timescale 1ns/1ps
module mtr_resolver_chk #(
  parameter int IDX_W   = 6,
  parameter int DEF_IDX = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_glob_bit,
  input logic             lk_valid,
  input logic             res_valid,
  input logic [7:0]       res_type
);
  logic en_seen;
  always_ff @(posedge clk) begin
    if (rst)
      en_seen <= 1'b0;
    else if (wr_en && wr_idx == IDX_W'(DEF_IDX))
      en_seen <= wr_glob_bit;
  end

  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_type == 8'd0 || res_type == 8'd1 || res_type == 8'd4 ||
                   res_type == 8'd5 || res_type == 8'd6));

  assert_disabled_uc_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !en_seen) |=> (res_type == 8'd0));
endmodule

bind mtr_resolver mtr_resolver_chk #(.IDX_W(IDX_W), .DEF_IDX(DEF_IDX)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_glob_bit(wr_data[11]),
  .lk_valid(lk_valid), .res_valid(res_valid), .res_type(res_type)
);

// File: tb/tb_mtr_resolver.sv
`timescale 1ns/1ps
module tb_mtr_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        lk_valid = 1'b0;
  logic [39:0] lk_addr = '0;
  logic        res_valid;
  logic [7:0]  res_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mtr_resolver dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid), .res_type(res_type)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] idx, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [39:0] a, input logic [7:0] exp);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " valid"}, 64'(res_valid), 64'd1);
    check({req, " type"}, 64'(res_type), 64'(exp));
  endtask

  // Reset state, idle behaviour and disabled-global results: R3, R4
  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R3 reset valid", 64'(res_valid), 64'd0);
    lookup("R4 reset uc", 40'h0, 8'd0);
    @(negedge clk);
    check("R3 idle after lookup", 64'(res_valid), 64'd0);
  endtask

  // Default type, unknown code R1, no match R9
  task automatic t_default;
    do_write(6'd32, 64'h802);
    lookup("R1 unknown default", 40'h12345000, 8'd0);
    do_write(6'd32, 64'h806);
    lookup("R9 default wb", 40'h12345000, 8'd6);
  endtask

  // Fixed table loaded, fixed enable off, var range 0: R2, R6, R7
  task automatic t_fixed_off;
    logic [7:0] legal [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
    for (int r = 0; r < 11; r++) begin
      logic [63:0] d = '0;
      for (int b = 0; b < 8; b++) d[b*8 +: 8] = legal[(r*8 + b) % 5];
      do_write(6'(r), d);
    end
    lookup("R6 fixed off default", 40'hC0000, 8'd6);
    do_write(6'd16, 64'h1);
    do_write(6'd17, 64'h000000FFFF000800);
    lookup("R6 fixed off var", 40'hC0000, 8'd1);
    lookup("R7 var covers", 40'h200000, 8'd1);
  endtask

  // Fixed layout and priority: R5
  task automatic t_fixed_on;
    do_write(6'd32, 64'hC06);
    lookup("R5 entry0", 40'h00000, 8'd0);
    lookup("R5 entry7", 40'h7FFFF, 8'd4);
    lookup("R5 entry8", 40'h80000, 8'd5);
    lookup("R5 entry13", 40'h94000, 8'd5);
    lookup("R5 entry23", 40'hBFFFF, 8'd5);
    lookup("R5 entry24", 40'hC0000, 8'd6);
    lookup("R5 entry29", 40'hC5000, 8'd6);
    lookup("R5 entry87", 40'hFFFFF, 8'd4);
    lookup("R5 above 1MiB", 40'h100000, 8'd1);
  endtask

  // Active flag and masked compare: R7
  task automatic t_var_active;
    do_write(6'd18, 64'h0000000100000000);
    do_write(6'd19, 64'h000000FFFFFFF000);
    lookup("R7 inactive ignored", 40'h1_0000_0000, 8'd6);
    do_write(6'd19, 64'h000000FFFFFFF800);
    lookup("R7 active page", 40'h1_0000_0000, 8'd0);
    lookup("R7 next page", 40'h1_0000_1000, 8'd6);
  endtask

  // Overlap combination: R8
  task automatic t_overlap;
    do_write(6'd20, 64'h20000006); do_write(6'd21, 64'h000000FFF0000800);
    do_write(6'd22, 64'h20000004); do_write(6'd23, 64'h000000FFFF000800);
    do_write(6'd24, 64'h22000005); do_write(6'd25, 64'h000000FFFF000800);
    do_write(6'd26, 64'h23000006); do_write(6'd27, 64'h000000FFFF000800);
    do_write(6'd28, 64'h24000000); do_write(6'd29, 64'h000000FFFF000800);
    lookup("R8 wb+wt", 40'h20000000, 8'd4);
    lookup("R8 single wb", 40'h21000000, 8'd6);
    lookup("R8 wb+wp", 40'h22000000, 8'd0);
    lookup("R8 wb+wb", 40'h23000000, 8'd6);
    lookup("R8 wb+uc", 40'h24000000, 8'd0);
  endtask

  // Top-of-memory-2 window: R10
  task automatic t_tom2;
    do_write(6'd32, 64'hC04);
    do_write(6'd33, 64'h0000000200800FFF);
    lookup("R10 inside", 40'h1_8000_0000, 8'd6);
    lookup("R10 last page", 40'h2_007F_F000, 8'd6);
    lookup("R10 at limit", 40'h2_0080_0000, 8'd4);
    lookup("R10 below 4GiB", 40'h0_FFFF_F000, 8'd4);
    lookup("R10 overrides var", 40'h1_0000_0000, 8'd6);
    do_write(6'd33, 64'h0);
    lookup("R10 zero off", 40'h1_8000_0000, 8'd4);
    lookup("R10 zero var back", 40'h1_0000_0000, 8'd0);
  endtask

  // Same-cycle write and lookup: R11
  task automatic t_same_cycle;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 40'h30000000;
    wr_en = 1'b1; wr_idx = 6'd32; wr_data = 64'hC06;
    @(negedge clk);
    lk_valid = 1'b0; wr_en = 1'b0;
    check("R11 old value", 64'(res_type), 64'd4);
    lookup("R11 new value", 40'h30000000, 8'd6);
  endtask

  // Global enable clear with ranges loaded: R4
  task automatic t_global_off;
    do_write(6'd32, 64'h406);
    lookup("R4 off var", 40'h20000000, 8'd0);
    lookup("R4 off fixed", 40'hC0000, 8'd0);
  endtask

  initial begin
    t_reset();
    t_default();
    t_fixed_off();
    t_fixed_on();
    t_var_active();
    t_overlap();
    t_tom2();
    t_same_cycle();
    t_global_off();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule